// File: doc/BRIEF.md
# Symbol reliability ranking unit

This unit ranks the symbols of a hard initial estimate by how likely each one is to be wrong, so a later search stage can spend its effort only on the weakest positions. The estimate holds P QPSK symbols. An effective channel matrix arrives one row per clock cycle, and the matching element of the received vector arrives in the same cycle.

For each symbol position the unit tries the three other QPSK points in that position while every other position keeps its estimated value. For each trial it sums the squared Euclidean distance between the received vector and the channel applied to the trial vector, one row per cycle. A symbol's reliability metric is the smallest of its three trial distances. A low metric means a nearby alternative explains the received data almost as well, so the symbols with the lowest metrics are reported as least reliable.

A start pulse latches the estimate and clears all accumulators. Rows are then streamed in. After the last row, an iterative minimum search emits NE symbol indices and a one-cycle done pulse.

Top module: `sym_rel_rank`

## Requirements
- R1: While reset is asserted and after its release, before any result, `done_o` is 0 and `idx_o` is all zeros.
- R2: `start_i` latches `est_i` and clears every accumulator. A start during row accumulation discards the rows taken so far, and the next result depends only on rows after the latest start. No done pulse follows a start on the next cycle.
- R3: A row is taken only on a clock edge where `row_valid_i` is high and the unit is accumulating. Cycles with `row_valid_i` low, and rows presented while idle, change no result and raise no done pulse.
- R4: Symbol k occupies `est_i[2k+1:2k]`. Bit 2k is the real sign and bit 2k+1 is the imaginary sign, with 0 meaning +1 and 1 meaning −1. Channel entry k of a row is `h_re_i[k*W +: W]` / `h_im_i[k*W +: W]`, signed two's complement. The received element is signed on `y_re_i` / `y_im_i`.
- R5: The metric of symbol k is the minimum, over the three QPSK points other than its estimate, of the sum over all P rows of |y_t − Σ_m h_t,m·s_m|², where s is the estimate with position k replaced by the trial point.
- R6: Each trial accumulator saturates at 2^ACC_W − 1 and never wraps.
- R7: `idx_o` carries NE symbol indices of IW bits each, in ascending metric order, with slot 0 in bits [IW-1:0]. Equal metrics are ordered by lower symbol index first.
- R8: `done_o` is high for exactly one cycle, NE cycles after the clock edge that takes the P-th row. `idx_o` changes only together with `done_o` and holds until the next result.
- R9: The NE reported indices are all different.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Latch estimate, clear accumulators, begin a new ranking |
| est_i | input | 2*P | Hard QPSK estimate, two sign bits per symbol |
| row_valid_i | input | 1 | Current channel row and received element are valid |
| h_re_i | input | P*W | Real parts of the current channel row |
| h_im_i | input | P*W | Imaginary parts of the current channel row |
| y_re_i | input | W | Real part of the current received element |
| y_im_i | input | W | Imaginary part of the current received element |
| done_o | output | 1 | One-cycle pulse: `idx_o` holds a new result |
| idx_o | output | NE*IW | Indices of the NE least reliable symbols |

## Verification
The only timed result is the index set. It is due NE cycles after the edge that accepts the last row, because one selection cycle is needed per reported index. The bench records the cycle in which it drives the last row and stores the due cycle with the expected indices. The monitor compares both the index vector and the arrival cycle whenever `done_o` is seen. Checks are sampled on the falling edge, and for the idle-row and restart cases the bench also confirms that no extra done pulse appears.

// File: rtl/sym_rel_pkg.sv
package sym_rel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_SEL  = 2'd2
  } rank_state_e;
endpackage

// File: rtl/sym_rel_residual.sv
// Base residual of one row: y_t - h_t . x
module sym_rel_residual #(
  parameter int P     = 8,
  parameter int W     = 12,
  parameter int RES_W = 18
) (
  input  logic [P*W-1:0]          h_re_i,
  input  logic [P*W-1:0]          h_im_i,
  input  logic [W-1:0]            y_re_i,
  input  logic [W-1:0]            y_im_i,
  input  logic [2*P-1:0]          est_i,
  output logic signed [RES_W-1:0] r_re_o,
  output logic signed [RES_W-1:0] r_im_o
);
  logic signed [RES_W-1:0] hr, hi, acc_re, acc_im;

  always_comb begin
    acc_re = RES_W'($signed(y_re_i));
    acc_im = RES_W'($signed(y_im_i));
    hr = '0;
    hi = '0;
    for (int k = 0; k < P; k++) begin
      hr = RES_W'($signed(h_re_i[k*W +: W]));
      hi = RES_W'($signed(h_im_i[k*W +: W]));
      // real: hr*xr - hi*xi ; imag: hr*xi + hi*xr
      acc_re = acc_re - (est_i[2*k] ? -hr : hr) + (est_i[2*k+1] ? -hi : hi);
      acc_im = acc_im - (est_i[2*k+1] ? -hr : hr) - (est_i[2*k] ? -hi : hi);
    end
  end

  assign r_re_o = acc_re;
  assign r_im_o = acc_im;
endmodule

// File: rtl/sym_rel_cand_acc.sv
// Three substitution trials for one symbol position, min of the sums.
module sym_rel_cand_acc #(
  parameter int W     = 12,
  parameter int RES_W = 18,
  parameter int E_W   = 20,
  parameter int ACC_W = 40
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    en_i,
  input  logic signed [RES_W-1:0] r_re_i,
  input  logic signed [RES_W-1:0] r_im_i,
  input  logic [W-1:0]            h_re_i,
  input  logic [W-1:0]            h_im_i,
  input  logic [1:0]              x_i,
  output logic [ACC_W-1:0]        metric_o
);
  localparam int SQ_W  = 2 * E_W + 1;
  localparam int EXT_W = ((ACC_W > SQ_W) ? ACC_W : SQ_W) + 1;
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  // h * d, where d is 0 or +-2 on one axis
  function automatic logic signed [E_W-1:0] dbl_term(input logic [W-1:0] h,
                                                      input logic flip,
                                                      input logic xb);
    logic signed [E_W-1:0] hx;
    hx = E_W'($signed(h));
    hx = hx + hx;
    if (!flip) return '0;
    return xb ? hx : -hx;
  endfunction

  logic [ACC_W-1:0] acc_w [3];

  for (genvar j = 0; j < 3; j++) begin : g_trial
    localparam logic [1:0] FLIP = 2'(j + 1);
    logic signed [E_W-1:0]   e_re, e_im;
    logic signed [2*E_W-1:0] q_re, q_im;
    logic [SQ_W-1:0]         sq;
    logic [EXT_W-1:0]        tot;
    logic [ACC_W-1:0]        acc_q;

    assign e_re = E_W'(r_re_i)
                - (dbl_term(h_re_i, FLIP[0], x_i[0]) - dbl_term(h_im_i, FLIP[1], x_i[1]));
    assign e_im = E_W'(r_im_i)
                - (dbl_term(h_re_i, FLIP[1], x_i[1]) + dbl_term(h_im_i, FLIP[0], x_i[0]));
    assign q_re = (2*E_W)'(e_re) * (2*E_W)'(e_re);
    assign q_im = (2*E_W)'(e_im) * (2*E_W)'(e_im);
    assign sq   = SQ_W'($unsigned(q_re)) + SQ_W'($unsigned(q_im));
    assign tot  = EXT_W'(acc_q) + EXT_W'(sq);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      acc_q <= '0;
      else if (clear_i) acc_q <= '0;
      else if (en_i)    acc_q <= (tot > EXT_W'(ACC_MAX)) ? ACC_MAX : tot[ACC_W-1:0];
    end

    assign acc_w[j] = acc_q;
  end

  always_comb begin
    metric_o = acc_w[0];
    if (acc_w[1] < metric_o) metric_o = acc_w[1];
    if (acc_w[2] < metric_o) metric_o = acc_w[2];
  end
endmodule

// File: rtl/sym_rel_select.sv
// Lowest unmasked metric, lower index wins ties.
module sym_rel_select #(
  parameter int P     = 8,
  parameter int ACC_W = 40,
  parameter int IW    = 3
) (
  input  logic [P*ACC_W-1:0] metric_i,
  input  logic [P-1:0]       mask_i,
  output logic [IW-1:0]      idx_o
);
  logic             found;
  logic [ACC_W-1:0] best;

  always_comb begin
    found = 1'b0;
    best  = '0;
    idx_o = '0;
    for (int k = 0; k < P; k++) begin
      if (!mask_i[k] && (!found || metric_i[k*ACC_W +: ACC_W] < best)) begin
        found = 1'b1;
        best  = metric_i[k*ACC_W +: ACC_W];
        idx_o = IW'(k);
      end
    end
  end
endmodule

// File: rtl/sym_rel_rank.sv
module sym_rel_rank #(
  parameter int P     = 8,
  parameter int NE    = 2,
  parameter int W     = 12,
  parameter int ACC_W = 40,
  localparam int IW   = (P > 1) ? $clog2(P) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [2*P-1:0]  est_i,
  input  logic            row_valid_i,
  input  logic [P*W-1:0]  h_re_i,
  input  logic [P*W-1:0]  h_im_i,
  input  logic [W-1:0]    y_re_i,
  input  logic [W-1:0]    y_im_i,
  output logic            done_o,
  output logic [NE*IW-1:0] idx_o
);
  import sym_rel_pkg::*;

  localparam int RES_W = W + 3 + $clog2(P);
  localparam int E_W   = RES_W + 2;
  localparam int SW    = (NE > 1) ? $clog2(NE) : 1;

  rank_state_e       state_q;
  logic [2*P-1:0]    est_q;
  logic [IW-1:0]     row_q;
  logic [SW-1:0]     sel_q;
  logic [P-1:0]      mask_q, mask_nxt;
  logic [NE*IW-1:0]  work_q, work_nxt;
  logic [IW-1:0]     pick_idx;
  logic              acc_en;
  logic [P*ACC_W-1:0] metric_flat;
  logic signed [RES_W-1:0] r_re, r_im;

  assign acc_en = (state_q == ST_ACC) && row_valid_i && !start_i;

  sym_rel_residual #(.P(P), .W(W), .RES_W(RES_W)) u_res (
    .h_re_i (h_re_i),
    .h_im_i (h_im_i),
    .y_re_i (y_re_i),
    .y_im_i (y_im_i),
    .est_i  (est_q),
    .r_re_o (r_re),
    .r_im_o (r_im)
  );

  for (genvar k = 0; k < P; k++) begin : g_sym
    sym_rel_cand_acc #(.W(W), .RES_W(RES_W), .E_W(E_W), .ACC_W(ACC_W)) u_acc (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clear_i  (start_i),
      .en_i     (acc_en),
      .r_re_i   (r_re),
      .r_im_i   (r_im),
      .h_re_i   (h_re_i[k*W +: W]),
      .h_im_i   (h_im_i[k*W +: W]),
      .x_i      (est_q[2*k +: 2]),
      .metric_o (metric_flat[k*ACC_W +: ACC_W])
    );
  end

  sym_rel_select #(.P(P), .ACC_W(ACC_W), .IW(IW)) u_sel (
    .metric_i (metric_flat),
    .mask_i   (mask_q),
    .idx_o    (pick_idx)
  );

  always_comb begin
    work_nxt = work_q;
    work_nxt[int'(sel_q)*IW +: IW] = pick_idx;
    mask_nxt = mask_q | (P'(1) << pick_idx);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      est_q   <= '0;
      row_q   <= '0;
      sel_q   <= '0;
      mask_q  <= '0;
      work_q  <= '0;
      idx_o   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        state_q <= ST_ACC;
        est_q   <= est_i;
        row_q   <= '0;
      end else begin
        unique case (state_q)
          ST_ACC: if (row_valid_i) begin
            if (row_q == IW'(P - 1)) begin
              state_q <= ST_SEL;
              sel_q   <= '0;
              mask_q  <= '0;
            end else begin
              row_q <= row_q + 1'b1;
            end
          end
          ST_SEL: begin
            work_q <= work_nxt;
            mask_q <= mask_nxt;
            if (sel_q == SW'(NE - 1)) begin
              state_q <= ST_IDLE;
              idx_o   <= work_nxt;
              done_o  <= 1'b1;
            end else begin
              sel_q <= sel_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sym_rel_rank_chk.sv
module sym_rel_rank_chk #(
  parameter int NE = 2,
  parameter int IW = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            done_o,
  input logic [NE*IW-1:0] idx_o
);
  assert_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(idx_o));

  assert_start_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);

  for (genvar a = 0; a < NE; a++) begin : g_a
    for (genvar b = a + 1; b < NE; b++) begin : g_b
      assert_distinct_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (idx_o[a*IW +: IW] != idx_o[b*IW +: IW]));
    end
  end
endmodule

bind sym_rel_rank sym_rel_rank_chk #(.NE(NE), .IW(IW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .done_o  (done_o),
  .idx_o   (idx_o)
);

// File: tb/tb_sym_rel_rank.sv
module tb_sym_rel_rank;
  localparam int P     = 8;
  localparam int NE    = 2;
  localparam int W     = 12;
  localparam int ACC_W = 32;
  localparam int IW    = $clog2(P);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [2*P-1:0] est_i = '0;
  logic row_valid_i = 1'b0;
  logic [P*W-1:0] h_re_i = '0, h_im_i = '0;
  logic [W-1:0] y_re_i = '0, y_im_i = '0;
  logic done_o;
  logic [NE*IW-1:0] idx_o;

  always #5 clk = ~clk;

  sym_rel_rank #(.P(P), .NE(NE), .W(W), .ACC_W(ACC_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .est_i(est_i),
    .row_valid_i(row_valid_i), .h_re_i(h_re_i), .h_im_i(h_im_i),
    .y_re_i(y_re_i), .y_im_i(y_im_i), .done_o(done_o), .idx_o(idx_o)
  );

  typedef struct {
    logic [NE*IW-1:0] idx;
    int               due;
    string            tag;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int compared = 0, mismatched = 0, cyc = 0, dn_cnt = 0;
  logic done_prev = 1'b0;
  int hre[P][P], him[P][P], yre[P], yim[P];
  logic [2*P-1:0] est;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint sgn(logic b);
    return b ? -1 : 1;
  endfunction

  // Independent model: full residual per trial, saturating sum, min, ranked pick.
  task automatic compute_expected(output logic [NE*IW-1:0] ev);
    longint met[P];
    longint mx = (longint'(1) << ACC_W) - 1;
    bit used[P];
    ev = '0;
    for (int k = 0; k < P; k++) begin
      longint best = -1;
      for (int j = 1; j < 4; j++) begin
        logic [1:0] c = est[2*k +: 2] ^ 2'(j);
        longint acc = 0;
        for (int t = 0; t < P; t++) begin
          longint er = yre[t], ei = yim[t];
          for (int m = 0; m < P; m++) begin
            logic [1:0] s = (m == k) ? c : est[2*m +: 2];
            longint sr = sgn(s[0]), si = sgn(s[1]);
            er -= hre[t][m] * sr - him[t][m] * si;
            ei -= hre[t][m] * si + him[t][m] * sr;
          end
          acc += er * er + ei * ei;
          if (acc > mx) acc = mx;
        end
        if (best < 0 || acc < best) best = acc;
      end
      met[k] = best;
      used[k] = 1'b0;
    end
    for (int n = 0; n < NE; n++) begin
      int bi = -1;
      for (int k = 0; k < P; k++)
        if (!used[k] && (bi < 0 || met[k] < met[bi])) bi = k;
      used[bi] = 1'b1;
      ev[n*IW +: IW] = IW'(bi);
    end
  endtask

  task automatic fill(int mode);
    est = 16'($urandom);
    for (int t = 0; t < P; t++) begin
      for (int k = 0; k < P; k++) begin
        case (mode)
          0: begin hre[t][k] = $urandom_range(0, 100) - 50; him[t][k] = $urandom_range(0, 100) - 50; end
          1: begin hre[t][k] = $urandom_range(0, 4095) - 2048; him[t][k] = $urandom_range(0, 4095) - 2048; end
          2: begin hre[t][k] = 0; him[t][k] = 0; end
          default: begin hre[t][k] = -2048; him[t][k] = -2048; end
        endcase
      end
      case (mode)
        0: begin yre[t] = $urandom_range(0, 400) - 200; yim[t] = $urandom_range(0, 400) - 200; end
        1: begin yre[t] = $urandom_range(0, 4095) - 2048; yim[t] = $urandom_range(0, 4095) - 2048; end
        2: begin yre[t] = 0; yim[t] = 0; end
        default: begin yre[t] = 2047; yim[t] = 2047; end
      endcase
    end
  endtask

  task automatic drive_row(int t);
    row_valid_i = 1'b1;
    for (int k = 0; k < P; k++) begin
      h_re_i[k*W +: W] = W'(hre[t][k]);
      h_im_i[k*W +: W] = W'(him[t][k]);
    end
    y_re_i = W'(yre[t]);
    y_im_i = W'(yim[t]);
  endtask

  task automatic drive_junk();
    row_valid_i = 1'b1;
    h_re_i = {3{32'($urandom)}};
    h_im_i = {3{32'($urandom)}};
    y_re_i = 12'($urandom);
    y_im_i = 12'($urandom);
  endtask

  task automatic run_case(bit gaps, string tag);
    exp_t x;
    compute_expected(x.idx);
    x.tag = tag;
    @(negedge clk);
    start_i = 1'b1;
    est_i = est;
    @(negedge clk);
    start_i = 1'b0;
    est_i = ~est;  // must have been latched at start
    for (int t = 0; t < P; t++) begin
      if (gaps && t > 0) begin
        drive_junk();
        row_valid_i = 1'b0;
        @(negedge clk);
      end
      drive_row(t);
      if (t == P - 1) begin
        x.due = cyc + 1 + NE;
        q.push_back(x);
      end
      @(negedge clk);
    end
    row_valid_i = 1'b0;
    for (int i = 0; i < 200 && q.size() != 0; i++) @(negedge clk);
    if (q.size() != 0) begin
      compared++; mismatched++;
      $display("FAIL R8 %s: done missing, actual=0 expected=1", tag);
      q.delete();
    end
    repeat (2) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) begin
        dn_cnt++;
        compared++;
        if (done_prev) begin
          mismatched++;
          $display("FAIL R8 pulse width: actual=2+ cycles expected=1");
        end
        if (q.size() == 0) begin
          compared++; mismatched++;
          $display("FAIL R3 unexpected done: actual=1 expected=0");
        end else begin
          e = q.pop_front();
          compared++;
          if (idx_o !== e.idx) begin
            mismatched++;
            $display("FAIL %s R7 indices: actual=%h expected=%h", e.tag, idx_o, e.idx);
          end
          compared++;
          if (cyc != e.due) begin
            mismatched++;
            $display("FAIL R8 %s latency: actual=%0d expected=%0d", e.tag, cyc, e.due);
          end
        end
      end
      done_prev = done_o;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int snap;
    repeat (3) @(negedge clk);
    compared++;
    if (done_o !== 1'b0 || idx_o !== '0) begin
      mismatched++;
      $display("FAIL R1 in reset: actual=%b/%h expected=0/0", done_o, idx_o);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    compared++;
    if (done_o !== 1'b0 || idx_o !== '0) begin
      mismatched++;
      $display("FAIL R1 after reset: actual=%b/%h expected=0/0", done_o, idx_o);
    end

    fill(0); run_case(1'b0, "R4 R5 small");
    for (int i = 0; i < 4; i++) begin fill(1); run_case(1'b0, "R5 full"); end
    fill(2); run_case(1'b0, "R7 R9 ties");
    fill(3); run_case(1'b0, "R6 saturate");
    fill(1); run_case(1'b1, "R3 gaps");

    // R2: restart mid-stream discards earlier rows
    fill(1);
    @(negedge clk);
    start_i = 1'b1; est_i = 16'($urandom);
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 3; i++) begin drive_junk(); @(negedge clk); end
    row_valid_i = 1'b0;
    run_case(1'b0, "R2 restart");

    // R3: rows while idle are ignored
    snap = dn_cnt;
    for (int i = 0; i < P + NE + 4; i++) begin drive_junk(); @(negedge clk); end
    row_valid_i = 1'b0;
    repeat (NE + 3) @(negedge clk);
    compared++;
    if (dn_cnt != snap || idx_o !== q.size() * 0 + idx_o) begin
      mismatched++;
      $display("FAIL R3 idle rows: actual=%0d dones expected=%0d", dn_cnt, snap);
    end
    fill(0); run_case(1'b0, "R3 after idle");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule